// File: doc/BRIEF.md
# Hypervisor Extension Control Register Access Checker

This block decides, in a single combinational step, what happens when an instruction tries to read or write the extended hypervisor control register. The decode stage of a core presents three sets of inputs:

- the operand encoding of the system-register access;
- the exception level the access comes from;
- the virtualization and debug state that governs it.

The block answers with exactly one outcome. The access can be undefined, trap to EL2, trap to EL3, be redirected to a memory slot at a fixed offset, or go straight to the register. For trap outcomes the block also supplies the exception class. For the redirect outcome it supplies the memory offset and the transfer direction.

When the operand encoding does not name this register, the block reports that it is not selected and holds every other output low. Other decoders on the same bus can then claim the access. The register storage and the memory transfer are handled elsewhere.

A build parameter moves the check for "halted with secure debug disabled and the enable from EL3 clear" to the front of the EL2 decision chain. The outcome does not change, only the logic structure. This lets integration match the order its exception-priority logic expects.

Top module: `hxc_access_check`

## Requirements
- R1: The register is selected only when op0=2'b11, op1=3'b100, crn=4'b0001, crm=4'b0010 and op2=3'b010. Reads and writes use the same encoding. For any other encoding, sel_hit is 0 and every result flag, acc_write, exc_class and mem_offset are 0.
- R2: A selected access with cur_el=0 sets res_undef.
- R3: A selected access with cur_el=1, el2_en=1, nv=1 and nv2=1 sets res_mem with mem_offset=12'h0A0.
- R4: A selected access with cur_el=1, el2_en=1, nv=1 and nv2=0 sets res_trap_el2 with exc_class=6'h18. Every other selected access at cur_el=1 sets res_undef.
- R5: A selected access with cur_el=2, el3_present=1 and hx_enable=0 sets res_trap_el3 with exc_class=6'h18. If halted=1 and sdd=1 as well, it sets res_undef instead.
- R6: A selected access with cur_el=2 that meets no condition of R5 sets res_direct. A selected access with cur_el=3 always sets res_direct.
- R7: For a selected access, exactly one of res_undef, res_trap_el2, res_trap_el3, res_mem and res_direct is 1. exc_class is 0 unless a trap flag is set. mem_offset is 0 unless res_mem is set.
- R8: is_write never changes the outcome. acc_write equals is_write when res_mem or res_direct is set, and is 0 otherwise.
- R9: Setting the parameter EARLY_SDD_UNDEF to 1 gives the same outputs as 0 for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_el | input | 2 | Exception level of the access (0 to 3) |
| is_write | input | 1 | 1 for a register write, 0 for a read |
| op0 | input | 2 | Operand encoding field op0 |
| op1 | input | 3 | Operand encoding field op1 |
| crn | input | 4 | Operand encoding field CRn |
| crm | input | 4 | Operand encoding field CRm |
| op2 | input | 3 | Operand encoding field op2 |
| el2_en | input | 1 | EL2 is enabled in the current security state |
| nv | input | 1 | Nested-virtualization trap bit |
| nv2 | input | 1 | Nested-virtualization memory-redirect bit |
| el3_present | input | 1 | EL3 is implemented |
| hx_enable | input | 1 | Enable for this register granted from EL3 |
| halted | input | 1 | Core is in debug halt |
| sdd | input | 1 | Secure debug is disabled |
| sel_hit | output | 1 | Encoding names this register |
| res_undef | output | 1 | Access is undefined |
| res_trap_el2 | output | 1 | Access traps to EL2 |
| res_trap_el3 | output | 1 | Access traps to EL3 |
| res_mem | output | 1 | Access is redirected to memory |
| res_direct | output | 1 | Access goes to the register |
| acc_write | output | 1 | Transfer direction for memory or register access |
| exc_class | output | 6 | Exception class on a trap, else 0 |
| mem_offset | output | 12 | Memory offset on redirect, else 0 |

## Verification
With the correct encoding, the bench sweeps every combination of exception level, direction and the seven state flags. Each combination is compared against an arithmetic priority model. This sweep separates the EL1 memory-redirect case from the EL1 trap case. It also separates the halted, secure-debug case from the EL3 trap, and it shows that the direction input changes only acc_write.

A second sweep walks all 65536 operand encodings from EL3 with the direction alternating. It confirms that the single matching encoding alone gives a direct access and that every near miss leaves all outputs quiet.

Both sweeps drive two instances side by side, one for each setting of the priority parameter. Any difference between the two shows up as a mismatch.

// File: rtl/hxc_pkg.sv
package hxc_pkg;

    typedef enum logic [2:0] {
        RES_NONE   = 3'd0,
        RES_UNDEF  = 3'd1,
        RES_TRAP2  = 3'd2,
        RES_TRAP3  = 3'd3,
        RES_MEM    = 3'd4,
        RES_DIRECT = 3'd5
    } res_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    typedef struct packed {
        logic el2_en;
        logic nv;
        logic nv2;
        logic el3_present;
        logic hx_enable;
        logic halted;
        logic sdd;
    } ctl_t;

    localparam sysenc_t TARGET_ENC = '{op0: 2'b11, op1: 3'b100, crn: 4'b0001,
                                       crm: 4'b0010, op2: 3'b010};

    function automatic logic secure_halt(input ctl_t c);
        return c.halted && c.sdd;
    endfunction

    function automatic logic el3_gate_closed(input ctl_t c);
        return c.el3_present && !c.hx_enable;
    endfunction

endpackage

// File: rtl/hxc_enc_match.sv
module hxc_enc_match
    import hxc_pkg::*;
(
    input  sysenc_t enc,
    output logic    hit
);
    always_comb begin
        hit = (enc.op0 == TARGET_ENC.op0) && (enc.op1 == TARGET_ENC.op1) &&
              (enc.crn == TARGET_ENC.crn) && (enc.crm == TARGET_ENC.crm) &&
              (enc.op2 == TARGET_ENC.op2);
    end
endmodule

// File: rtl/hxc_el1_path.sv
module hxc_el1_path
    import hxc_pkg::*;
(
    input  ctl_t ctl,
    output res_e res
);
    always_comb begin
        if (ctl.el2_en && ctl.nv && ctl.nv2)
            res = RES_MEM;
        else if (ctl.el2_en && ctl.nv)
            res = RES_TRAP2;
        else
            res = RES_UNDEF;
    end
endmodule

// File: rtl/hxc_el2_path.sv
module hxc_el2_path
    import hxc_pkg::*;
#(
    parameter bit EARLY_SDD_UNDEF = 1'b0
) (
    input  ctl_t ctl,
    output res_e res
);
    generate
        if (EARLY_SDD_UNDEF) begin : g_early
            always_comb begin
                if (secure_halt(ctl) && el3_gate_closed(ctl))
                    res = RES_UNDEF;
                else if (el3_gate_closed(ctl))
                    res = RES_TRAP3;
                else
                    res = RES_DIRECT;
            end
        end else begin : g_late
            always_comb begin
                if (el3_gate_closed(ctl))
                    res = secure_halt(ctl) ? RES_UNDEF : RES_TRAP3;
                else
                    res = RES_DIRECT;
            end
        end
    endgenerate
endmodule

// File: rtl/hxc_result_expand.sv
module hxc_result_expand
    import hxc_pkg::*;
#(
    parameter int          EC_W    = 6,
    parameter logic [EC_W-1:0]  EC_VAL  = 6'h18,
    parameter int          OFS_W   = 12,
    parameter logic [OFS_W-1:0] OFS_VAL = 12'h0A0
) (
    input  res_e             res,
    input  logic             wr,
    output logic             f_undef,
    output logic             f_trap2,
    output logic             f_trap3,
    output logic             f_mem,
    output logic             f_direct,
    output logic             f_write,
    output logic [EC_W-1:0]  ec,
    output logic [OFS_W-1:0] ofs
);
    always_comb begin
        f_undef  = (res == RES_UNDEF);
        f_trap2  = (res == RES_TRAP2);
        f_trap3  = (res == RES_TRAP3);
        f_mem    = (res == RES_MEM);
        f_direct = (res == RES_DIRECT);
        f_write  = wr && (f_mem || f_direct);
        ec       = (f_trap2 || f_trap3) ? EC_VAL : '0;
        ofs      = f_mem ? OFS_VAL : '0;
    end
endmodule

// File: rtl/hxc_access_check.sv
module hxc_access_check
    import hxc_pkg::*;
#(
    parameter bit EARLY_SDD_UNDEF = 1'b0,
    parameter int EC_W            = 6,
    parameter int OFS_W           = 12
) (
    input  logic [1:0]       cur_el,
    input  logic             is_write,
    input  logic [1:0]       op0,
    input  logic [2:0]       op1,
    input  logic [3:0]       crn,
    input  logic [3:0]       crm,
    input  logic [2:0]       op2,
    input  logic             el2_en,
    input  logic             nv,
    input  logic             nv2,
    input  logic             el3_present,
    input  logic             hx_enable,
    input  logic             halted,
    input  logic             sdd,
    output logic             sel_hit,
    output logic             res_undef,
    output logic             res_trap_el2,
    output logic             res_trap_el3,
    output logic             res_mem,
    output logic             res_direct,
    output logic             acc_write,
    output logic [EC_W-1:0]  exc_class,
    output logic [OFS_W-1:0] mem_offset
);
    localparam logic [EC_W-1:0]  EC_SYSREG = EC_W'(8'h18);
    localparam logic [OFS_W-1:0] NV_OFFSET = OFS_W'(16'h00A0);

    sysenc_t enc;
    ctl_t    ctl;
    res_e    el1_res, el2_res, final_res;
    logic    hit;

    assign enc = '{op0: op0, op1: op1, crn: crn, crm: crm, op2: op2};
    assign ctl = '{el2_en: el2_en, nv: nv, nv2: nv2, el3_present: el3_present,
                   hx_enable: hx_enable, halted: halted, sdd: sdd};

    hxc_enc_match u_match (.enc(enc), .hit(hit));
    hxc_el1_path  u_el1   (.ctl(ctl), .res(el1_res));
    hxc_el2_path #(.EARLY_SDD_UNDEF(EARLY_SDD_UNDEF)) u_el2 (.ctl(ctl), .res(el2_res));

    always_comb begin
        if (!hit)
            final_res = RES_NONE;
        else begin
            unique case (cur_el)
                2'd0:    final_res = RES_UNDEF;
                2'd1:    final_res = el1_res;
                2'd2:    final_res = el2_res;
                default: final_res = RES_DIRECT;
            endcase
        end
    end

    assign sel_hit = hit;

    hxc_result_expand #(
        .EC_W(EC_W), .EC_VAL(EC_SYSREG), .OFS_W(OFS_W), .OFS_VAL(NV_OFFSET)
    ) u_expand (
        .res(final_res), .wr(is_write),
        .f_undef(res_undef), .f_trap2(res_trap_el2), .f_trap3(res_trap_el3),
        .f_mem(res_mem), .f_direct(res_direct), .f_write(acc_write),
        .ec(exc_class), .ofs(mem_offset)
    );

    // Output-level checks against the port behaviour
    always_comb begin
        AST_QUIET_WHEN_MISS: assert (sel_hit || ({res_undef, res_trap_el2, res_trap_el3,
            res_mem, res_direct, acc_write} == '0 && exc_class == '0 && mem_offset == '0))
            else $error("unselected access drove an output"); // R1
        AST_EL0_UNDEF: assert (!(sel_hit && cur_el == 2'd0) || res_undef)
            else $error("EL0 access not undefined"); // R2
        AST_ONE_RESULT: assert (!sel_hit || $countones({res_undef, res_trap_el2,
            res_trap_el3, res_mem, res_direct}) == 1)
            else $error("result not one-hot"); // R7
        AST_EC_ON_TRAP: assert ((exc_class != '0) == (res_trap_el2 || res_trap_el3))
            else $error("exception class mismatch"); // R7
        AST_EL3_DIRECT: assert (!(sel_hit && cur_el == 2'd3) || res_direct)
            else $error("EL3 access not direct"); // R6
        AST_WRITE_ONLY_XFER: assert (!acc_write || (is_write && (res_mem || res_direct)))
            else $error("write flag on non-transfer"); // R8
    end
endmodule

// File: tb/hxc_access_check_test.sv
module hxc_access_check_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0] cur_el = '0, op0 = '0;
    logic [2:0] op1 = '0, op2 = '0;
    logic [3:0] crn = '0, crm = '0;
    logic is_write = 0, el2_en = 0, nv = 0, nv2 = 0, el3_present = 0;
    logic hx_enable = 0, halted = 0, sdd = 0;

    logic [28:0] out_a, out_b;
    int compared = 0;
    int mismatched = 0;

    hxc_access_check #(.EARLY_SDD_UNDEF(1'b0)) uut (
        .cur_el, .is_write, .op0, .op1, .crn, .crm, .op2, .el2_en, .nv, .nv2,
        .el3_present, .hx_enable, .halted, .sdd,
        .sel_hit(out_a[28]), .res_undef(out_a[27]), .res_trap_el2(out_a[26]),
        .res_trap_el3(out_a[25]), .res_mem(out_a[24]), .res_direct(out_a[23]),
        .acc_write(out_a[22]), .exc_class(out_a[21:16]), .mem_offset(out_a[11:0]));
    assign out_a[15:12] = '0;

    hxc_access_check #(.EARLY_SDD_UNDEF(1'b1)) uut_early (
        .cur_el, .is_write, .op0, .op1, .crn, .crm, .op2, .el2_en, .nv, .nv2,
        .el3_present, .hx_enable, .halted, .sdd,
        .sel_hit(out_b[28]), .res_undef(out_b[27]), .res_trap_el2(out_b[26]),
        .res_trap_el3(out_b[25]), .res_mem(out_b[24]), .res_direct(out_b[23]),
        .acc_write(out_b[22]), .exc_class(out_b[21:16]), .mem_offset(out_b[11:0]));
    assign out_b[15:12] = '0;

    // Reference model: {sel, undef, trap2, trap3, mem, direct, wr, ec[5:0], 0000, ofs[11:0]}
    function automatic logic [28:0] model();
        logic sel;
        int   r; // 0 none,1 undef,2 trap2,3 trap3,4 mem,5 direct
        logic [28:0] v;
        sel = (op0 == 2'd3) && (op1 == 3'd4) && (crn == 4'd1) && (crm == 4'd2) && (op2 == 3'd2);
        if (!sel) r = 0;
        else if (cur_el == 0) r = 1;
        else if (cur_el == 1) begin
            if (el2_en && nv && nv2) r = 4;
            else if (el2_en && nv) r = 2;
            else r = 1;
        end else if (cur_el == 2) begin
            if (el3_present && !hx_enable) r = (halted && sdd) ? 1 : 3;
            else r = 5;
        end else r = 5;
        v = '0;
        v[28] = sel;
        v[27] = (r == 1);
        v[26] = (r == 2);
        v[25] = (r == 3);
        v[24] = (r == 4);
        v[23] = (r == 5);
        v[22] = is_write && (r == 4 || r == 5);
        v[21:16] = (r == 2 || r == 3) ? 6'd24 : 6'd0;
        v[11:0]  = (r == 4) ? 12'd160 : 12'd0;
        return v;
    endfunction

    function automatic string tag();
        logic sel;
        sel = (op0 == 2'd3) && (op1 == 3'd4) && (crn == 4'd1) && (crm == 4'd2) && (op2 == 3'd2);
        if (!sel) return "R1";
        case (cur_el)
            2'd0: return "R2";
            2'd1: return (el2_en && nv && nv2) ? "R3" : "R4";
            2'd2: return (el3_present && !hx_enable) ? "R5" : "R6";
            default: return "R6";
        endcase
    endfunction

    task automatic check_now();
        logic [28:0] exp;
        exp = model();
        compared++;
        if (out_a !== exp) begin
            mismatched++;
            $display("FAIL %s/R7/R8 el=%0d wr=%0d: actual=%h expected=%h",
                     tag(), cur_el, is_write, out_a, exp);
        end
        compared++;
        if (out_b !== exp) begin
            mismatched++;
            $display("FAIL R9 (%s) early-priority instance: actual=%h expected=%h",
                     tag(), out_b, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_now(); // reset/idle state: unselected, R1
        // Sweep 1: target encoding, every control combination (R2..R9)
        op0 = 2'b11; op1 = 3'b100; crn = 4'b0001; crm = 4'b0010; op2 = 3'b010;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            {cur_el, is_write, el2_en, nv, nv2, el3_present, hx_enable, halted, sdd} = 10'(i);
            #5 check_now();
        end
        // Sweep 2: every encoding from EL3 (R1, R6, R8)
        cur_el = 2'd3; el2_en = 1; nv = 1; nv2 = 1; el3_present = 1;
        hx_enable = 0; halted = 1; sdd = 1;
        for (int e = 0; e < 65536; e++) begin
            @(negedge clk);
            {op0, op1, crn, crm, op2} = 16'(e);
            is_write = e[0];
            #5 check_now();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog (R1..all): actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule